// File: doc/BRIEF.md
# Instruction Address Unit with Circular Return Stack

This block produces the fetch address for a small microcontroller core whose instructions are 14 bits wide. It keeps a 13-bit program counter and updates it each cycle from one-hot control strobes raised by the instruction decoder. The strobes are: step, jump, subroutine call, return, interrupt entry and low-byte write. The decoder also supplies an 11-bit branch literal, a low-byte data value and the five-bit page latch.

Jumps and calls build their target from the literal and the page latch. Bit 3 of the latch selects the page bit. A low-byte write places the data in bits 7:0 and copies latch bits 4:0 into bits 12:8, so the upper byte is never written on its own. Calls and interrupts save the current fetch address in an eight-entry circular stack, and returns restore it. The stack has no visible pointer and raises no error on overflow or underflow. Every new address is folded into the implemented memory size. One cycle after any taken branch, a flush flag tells the fetch stage to discard its prefetched word.

Top module: `pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address becomes 0 and the flush flag is cleared, whatever strobes are asserted.
- R2: A step strobe alone advances the address by one, and an address past MEM_WORDS-1 folds to 0 (default MEM_WORDS = 4096).
- R3: A jump loads {latch[4:3], literal[10:0]} masked to MEM_WORDS-1, so latch bit 3 lands in address bit 11.
- R4: A call loads the same target as a jump and saves the current fetch address. A later return restores the saved addresses in last-in, first-out order.
- R5: An interrupt loads address 4 and saves the current fetch address on the stack.
- R6: A low-byte write loads {latch[4:0], data[7:0]} masked to MEM_WORDS-1. `pcl_o` always shows address bits 7:0.
- R7: The stack holds 8 entries. A ninth push overwrites the entry from the first push, so after nine calls the ninth return gives the last call's address again.
- R8: When strobes are asserted together, the priority is reset, then interrupt, then call, then return, then jump, then low-byte write, then step.
- R9: `flush_o` is high for the cycle after an edge at which an interrupt, call, return, jump or low-byte write took effect, and low after any other edge.
- R10: A pop from a logically empty stack returns the entry that the wrapped pointer selects. Straight after reset, this entry is 0.
- R11: With no strobe asserted, the fetch address holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance to the next sequential address |
| jump_i | input | 1 | Jump to literal plus page bits |
| call_i | input | 1 | Save address and jump to literal plus page bits |
| ret_i | input | 1 | Restore the last saved address |
| irq_i | input | 1 | Save address and enter the interrupt vector |
| lo_wr_i | input | 1 | Write the address low byte |
| lit_i | input | 11 | Branch literal |
| lo_data_i | input | 8 | Low-byte write data |
| page_i | input | 5 | Page latch value for bits 12:8 |
| fetch_addr_o | output | 13 | Current fetch address |
| pcl_o | output | 8 | Readable low byte of the address |
| flush_o | output | 1 | Discard the prefetched word |

## Verification
A table of strobe patterns checks each update source with latch values chosen so that a wrong page bit or a missed mask shows up in the address. These include a jump whose latch bit 4 must be dropped and a step from the top address that must fold to zero. Rows with several strobes raised together tell the priority order apart, because each competing source would produce a different address. A run of nine calls followed by nine returns shows that the oldest entry was overwritten and that the pointer wraps. A return straight after reset confirms the wrapped underflow value.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_STEP,
        ACT_LOWR,
        ACT_JUMP,
        ACT_RET,
        ACT_CALL,
        ACT_IRQ
    } pc_act_e;

    typedef struct packed {
        logic irq;
        logic call;
        logic jump;
        logic ret;
        logic lo_wr;
        logic step;
    } strobe_t;

    localparam int IRQ_VECTOR = 4;

    function automatic pc_act_e pick_action(strobe_t s);
        pc_act_e a;
        if (s.irq)        a = ACT_IRQ;
        else if (s.call)  a = ACT_CALL;
        else if (s.ret)   a = ACT_RET;
        else if (s.jump)  a = ACT_JUMP;
        else if (s.lo_wr) a = ACT_LOWR;
        else if (s.step)  a = ACT_STEP;
        else              a = ACT_HOLD;
        return a;
    endfunction

    function automatic logic is_branch(pc_act_e a);
        return (a != ACT_HOLD) && (a != ACT_STEP);
    endfunction

endpackage

// File: rtl/pcu_arb.sv
module pcu_arb
    import pcu_pkg::*;
(
    input  strobe_t strobes_i,
    output pc_act_e act_o,
    output logic    push_o,
    output logic    pop_o,
    output logic    branch_o
);
    always_comb begin
        act_o    = pick_action(strobes_i);
        push_o   = (act_o == ACT_CALL) || (act_o == ACT_IRQ);
        pop_o    = (act_o == ACT_RET);
        branch_o = is_branch(act_o);
    end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic [WIDTH-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;

    always_comb begin
        ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
        top_o  = slot_q[ptr_dn];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push_i) begin
            slot_q[ptr_q] <= push_data_i;
            ptr_q         <= ptr_up;
        end else if (pop_i) begin
            ptr_q <= ptr_dn;
        end
    end

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        push_i |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)); // R7
    AST_PTR_RETREAT: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> ptr_q == (($past(ptr_q) == '0) ? LAST : $past(ptr_q) - 1'b1)); // R10
    AST_PUSH_STORED: assert property (@(posedge clk) disable iff (rst)
        push_i |=> slot_q[$past(ptr_q)] == $past(push_data_i)); // R4
endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
    import pcu_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int LIT_W     = 11,
    parameter int MEM_WORDS = 4096
) (
    input  pc_act_e          act_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [LIT_W-1:0] lit_i,
    input  logic [7:0]       lo_data_i,
    input  logic [PC_W-9:0]  page_i,
    input  logic [PC_W-1:0]  pop_i,
    output logic [PC_W-1:0]  next_o
);
    localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);
    localparam logic [PC_W-1:0] VEC  = PC_W'(IRQ_VECTOR);

    logic [PC_W-1:0] raw;

    always_comb begin
        unique case (act_i)
            ACT_STEP:           raw = pc_i + 1'b1;
            ACT_LOWR:           raw = {page_i, lo_data_i};
            ACT_JUMP, ACT_CALL: raw = {page_i[PC_W-9:LIT_W-8], lit_i};
            ACT_RET:            raw = pop_i;
            ACT_IRQ:            raw = VEC;
            default:            raw = pc_i;
        endcase
        next_o = raw & MASK;
    end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import pcu_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int LIT_W     = 11,
    parameter int DEPTH     = 8,
    parameter int MEM_WORDS = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             jump_i,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic             irq_i,
    input  logic             lo_wr_i,
    input  logic [LIT_W-1:0] lit_i,
    input  logic [7:0]       lo_data_i,
    input  logic [PC_W-9:0]  page_i,
    output logic [PC_W-1:0]  fetch_addr_o,
    output logic [7:0]       pcl_o,
    output logic             flush_o
);
    localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);

    strobe_t         strobes;
    pc_act_e         act;
    logic            push, pop, branch;
    logic [PC_W-1:0] pc_q, pc_d, stack_top;
    logic            flush_q;

    assign strobes = '{irq: irq_i, call: call_i, jump: jump_i,
                       ret: ret_i, lo_wr: lo_wr_i, step: step_i};

    pcu_arb arb_i (
        .strobes_i (strobes),
        .act_o     (act),
        .push_o    (push),
        .pop_o     (pop),
        .branch_o  (branch)
    );

    pcu_ret_stack #(.DEPTH(DEPTH), .WIDTH(PC_W)) stack_i (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (pc_q),
        .top_o       (stack_top)
    );

    pcu_next_addr #(.PC_W(PC_W), .LIT_W(LIT_W), .MEM_WORDS(MEM_WORDS)) next_i (
        .act_i     (act),
        .pc_i      (pc_q),
        .lit_i     (lit_i),
        .lo_data_i (lo_data_i),
        .page_i    (page_i),
        .pop_i     (stack_top),
        .next_o    (pc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            flush_q <= 1'b0;
        end else begin
            pc_q    <= pc_d;
            flush_q <= branch;
        end
    end

    assign fetch_addr_o = pc_q;
    assign pcl_o        = pc_q[7:0];
    assign flush_o      = flush_q;

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rst)
        irq_i |=> fetch_addr_o == PC_W'(IRQ_VECTOR)); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (step_i && !irq_i && !call_i && !ret_i && !jump_i && !lo_wr_i)
        |=> fetch_addr_o == (($past(fetch_addr_o) + 1'b1) & MASK)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(step_i || irq_i || call_i || ret_i || jump_i || lo_wr_i) |=> $stable(fetch_addr_o)); // R11
    AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !irq_i && !call_i) |=> fetch_addr_o == $past(stack_top)); // R4
    AST_FLUSH_RAISED: assert property (@(posedge clk) disable iff (rst)
        (irq_i || call_i || ret_i || jump_i || lo_wr_i) |=> flush_o); // R9
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(irq_i || call_i || ret_i || jump_i || lo_wr_i) |=> !flush_o); // R9
endmodule

// File: tb/pc_unit_tb.sv
module pc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 0, jump_i = 0, call_i = 0, ret_i = 0, irq_i = 0, lo_wr_i = 0;
    logic [10:0] lit_i = '0;
    logic [7:0]  lo_data_i = '0;
    logic [4:0]  page_i = '0;
    logic [12:0] fetch_addr_o;
    logic [7:0]  pcl_o;
    logic        flush_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pc_unit dut_i (
        .clk(clk), .rst(rst), .step_i(step_i), .jump_i(jump_i), .call_i(call_i),
        .ret_i(ret_i), .irq_i(irq_i), .lo_wr_i(lo_wr_i), .lit_i(lit_i),
        .lo_data_i(lo_data_i), .page_i(page_i), .fetch_addr_o(fetch_addr_o),
        .pcl_o(pcl_o), .flush_o(flush_o)
    );

    // strobes {irq,call,jump,ret,lo_wr,step}, lit, data, page, expected address
    localparam int NV = 17;
    localparam logic [42:0] VEC [NV] = '{
        {6'b000001, 11'h000, 8'h00, 5'h00, 13'h0001},  // R2
        {6'b000001, 11'h000, 8'h00, 5'h00, 13'h0002},  // R2
        {6'b001000, 11'h123, 8'h00, 5'h08, 13'h0923},  // R3 page bit
        {6'b000001, 11'h000, 8'h00, 5'h00, 13'h0924},  // R2
        {6'b010000, 11'h050, 8'h00, 5'h10, 13'h0050},  // R4 call, bit 12 masked
        {6'b000001, 11'h000, 8'h00, 5'h00, 13'h0051},  // R2
        {6'b000100, 11'h000, 8'h00, 5'h00, 13'h0924},  // R4 return
        {6'b000010, 11'h000, 8'hAB, 5'h1F, 13'h0FAB},  // R6
        {6'b000001, 11'h000, 8'h00, 5'h00, 13'h0FAC},  // R2
        {6'b001000, 11'h7FF, 8'h00, 5'h18, 13'h0FFF},  // R3
        {6'b000001, 11'h000, 8'h00, 5'h00, 13'h0000},  // R2 fold
        {6'b100001, 11'h000, 8'h00, 5'h00, 13'h0004},  // R5 R8
        {6'b000100, 11'h000, 8'h00, 5'h00, 13'h0000},  // R5 saved address
        {6'b010011, 11'h200, 8'h33, 5'h00, 13'h0200},  // R8 call wins
        {6'b000100, 11'h000, 8'h00, 5'h00, 13'h0000},  // R4
        {6'b000011, 11'h000, 8'h10, 5'h02, 13'h0210},  // R8 write over step
        {6'b000000, 11'h000, 8'h00, 5'h00, 13'h0210}   // R11
    };

    task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] s, input logic [10:0] l, input logic [7:0] d,
                         input logic [4:0] p);
        {irq_i, call_i, jump_i, ret_i, lo_wr_i, step_i} = s;
        lit_i = l; lo_data_i = d; page_i = p;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(6'b000000, '0, '0, '0);
        drive(6'b000000, '0, '0, '0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset with strobes raised
        rst = 1'b1;
        drive(6'b110011, 11'h3FF, 8'hFF, 5'h1F);
        check("R1 addr", fetch_addr_o, 13'h0000);
        check("R1 flush", {12'h0, flush_o}, 13'h0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][42:37], VEC[i][36:26], VEC[i][25:18], VEC[i][17:13]);
            check($sformatf("R2-table row %0d addr", i), fetch_addr_o, VEC[i][12:0]);
            check("R6 low byte view", {5'h0, pcl_o}, {5'h0, VEC[i][7:0]});
            check("R9 flush", {12'h0, flush_o},
                  {12'h0, |VEC[i][42:38]});
        end

        // R10: return straight after reset gives 0
        do_reset();
        drive(6'b001000, 11'h155, 8'h00, 5'h00);
        drive(6'b000100, 11'h000, 8'h00, 5'h00);
        check("R10 empty pop", fetch_addr_o, 13'h0000);

        // R7: nine calls, nine returns
        do_reset();
        for (int k = 0; k < 9; k++) begin
            drive(6'b010000, 11'((k + 1) * 16), 8'h00, 5'h00);
            check("R4 call target", fetch_addr_o, 13'((k + 1) * 16));
        end
        drive(6'b000100, '0, '0, '0);
        check("R7 first return", fetch_addr_o, 13'h0080);
        for (int k = 7; k >= 1; k--) begin
            drive(6'b000100, '0, '0, '0);
            check("R7 lifo return", fetch_addr_o, 13'(k * 16));
        end
        drive(6'b000100, '0, '0, '0);
        check("R7 R10 overwritten slot", fetch_addr_o, 13'h0080);

        // R1: reset mid-run clears flush
        drive(6'b001000, 11'h077, 8'h00, 5'h00);
        rst = 1'b1;
        drive(6'b100000, '0, '0, '0);
        check("R1 mid-run addr", fetch_addr_o, 13'h0000);
        check("R1 mid-run flush", {12'h0, flush_o}, 13'h0000);
        rst = 1'b0;
        drive(6'b000000, '0, '0, '0);
        check("R11 idle after reset", fetch_addr_o, 13'h0000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule